// File: doc/BRIEF.md
# Mixed-Signal Capture Trigger Unit

This block decides the moment at which a capture should start. Each accepted sample carries a 10-bit ADC value and an 8-bit logic word. A configuration byte enables the trigger, selects one of four trigger modes and selects the edge polarity. It also holds the top two bits of the analog threshold. Separate bytes supply the low threshold bits, a logic pattern with its don't-care mask, a 16-bit holdoff split over two bytes, and a pulse-width limit counted in sample periods.

Control software first pulses the sequencer reset and then pulses arm. The unit then skips the programmed number of holdoff samples and hunts for the trigger condition. When the condition is met, it emits a single-cycle trigger pulse and latches a data-ready status code. A force input ends the hunt at once, whatever the configuration. The available conditions are an analog threshold crossing, a crossing qualified by how long the pulse lasts, and a masked match on the logic inputs.

Top module: `capture_trigger`

## Requirements
- R1: After reset, `status` reads 0x01 (waiting) and `trig_pulse` is low.
- R2: When `cfg_reg[7]` is 0, no sample-based trigger fires in any mode.
- R3: The threshold is {`cfg_reg[1:0]`, `thr_lo_reg`}. A sample counts as high when it is at or above the threshold. In mode `cfg_reg[6:5]`=00 the trigger fires on the sample that crosses the threshold: a low-to-high crossing when `cfg_reg[2]`=0, and a high-to-low crossing when `cfg_reg[2]`=1.
- R4: In mode 11 the trigger fires on any accepted sample whose `logic_in` equals `pat_value` on every bit where `pat_mask` is 0. Bits where the mask is 1 are ignored.
- R5: In mode 01 the pulse width is the number of samples from the selected-edge sample up to, but not including, the opposite-edge sample. The count saturates at 255. The trigger fires on the opposite-edge sample when width < `width_limit`.
- R6: In mode 10 the trigger fires on the opposite-edge sample when width >= `width_limit`.
- R7: After arming, the first {`holdoff_hi`, `holdoff_lo`} accepted samples cannot cause a trigger. Detection starts one cycle after the last of them.
- R8: Arm (`ctl_arm`=1 while `ctl_fsm_reset`=0) is accepted only from the idle state. Once a capture has completed, arm has no effect on `status`.
- R9: `ctl_force` fires the trigger at once while the unit is armed, including during holdoff and with `cfg_reg[7]`=0. In the idle state it has no effect.
- R10: `trig_pulse` is high for exactly one cycle, on the clock edge that accepts the deciding sample or force. From that edge, `status` reads 0x02 (data ready) and holds it until the sequencer reset.
- R11: `ctl_fsm_reset` returns the unit to idle on the next edge, with `status` 0x01. It has priority over arm and force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Accepts one sample on this edge |
| adc_sample | input | 10 | Analog sample value |
| logic_in | input | 8 | Logic channel sample |
| cfg_reg | input | 8 | Enable, mode, polarity, threshold high bits |
| thr_lo_reg | input | 8 | Threshold low bits |
| pat_value | input | 8 | Logic pattern value |
| pat_mask | input | 8 | Pattern don't-care mask (1 = ignore) |
| holdoff_lo | input | 8 | Holdoff count low byte |
| holdoff_hi | input | 8 | Holdoff count high byte |
| width_limit | input | 8 | Pulse-width limit in samples |
| ctl_fsm_reset | input | 1 | Sequencer reset |
| ctl_arm | input | 1 | Arm request |
| ctl_force | input | 1 | Force trigger |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| status | output | 8 | 0x01 waiting, 0x02 data ready |

## Verification
The width counter and the holdoff counter are hidden, but an error in either shows up at the ports. The trigger pulse lands one sample early or late, or it is missing on the sample that closes a pulse of exactly the limit length. A stale edge-history register shows up as a trigger on the first sample after arming that carries no real crossing. A sequencer stuck in the wrong state shows up at once as a wrong status code or a forced trigger that never appears. Each check therefore samples the outputs right after every single sample that is pushed, so any deviation is caught within one cycle of the sample that caused it.

// File: rtl/captrig_pkg.sv
package captrig_pkg;
    localparam int ADC_W   = 10;
    localparam int LOGIC_W = 8;
    localparam int REG_W   = 8;
    localparam int HOLD_W  = 2 * REG_W;

    typedef enum logic [1:0] {
        MODE_LEVEL   = 2'b00,
        MODE_NARROW  = 2'b01,
        MODE_WIDE    = 2'b10,
        MODE_PATTERN = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLDOFF,
        ST_HUNT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       enable;
        trig_mode_e mode;
        logic [1:0] spare;
        logic       falling;
        logic [1:0] thr_hi;
    } trig_cfg_t;

    localparam logic [REG_W-1:0] STAT_WAIT  = 8'h01;
    localparam logic [REG_W-1:0] STAT_READY = 8'h02;

    function automatic trig_cfg_t decode_cfg(input logic [REG_W-1:0] raw);
        return trig_cfg_t'(raw);
    endfunction

    function automatic logic [ADC_W-1:0] make_threshold(input trig_cfg_t c,
                                                        input logic [REG_W-1:0] lo);
        return {c.thr_hi, lo};
    endfunction

    function automatic logic [REG_W-1:0] sat_inc(input logic [REG_W-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/captrig_level.sv
module captrig_level
    import captrig_pkg::*;
#(
    parameter int W = ADC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_valid,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] thresh,
    output logic         rise,
    output logic         fall
);
    logic prev_above;
    logic above;

    assign above = (sample >= thresh);

    always_ff @(posedge clk) begin
        if (rst)
            prev_above <= 1'b0;
        else if (smp_valid)
            prev_above <= above;
    end

    assign rise = smp_valid &  above & ~prev_above;
    assign fall = smp_valid & ~above &  prev_above;
endmodule

// File: rtl/captrig_pattern.sv
module captrig_pattern
    import captrig_pkg::*;
#(
    parameter int W = LOGIC_W
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] value,
    input  logic [W-1:0] mask,
    output logic         match
);
    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = mask[i] | (data[i] == value[i]);
    end

    assign match = &bit_ok;
endmodule

// File: rtl/captrig_width.sv
module captrig_width
    import captrig_pkg::*;
#(
    parameter int CW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          track_en,
    input  logic          smp_valid,
    input  logic          lead_edge,
    input  logic          trail_edge,
    input  logic [CW-1:0] limit,
    output logic          meas_done,
    output logic          is_short
);
    logic          in_pulse;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !track_en) begin
            in_pulse <= 1'b0;
            cnt      <= '0;
        end else if (smp_valid) begin
            if (!in_pulse && lead_edge) begin
                in_pulse <= 1'b1;
                cnt      <= CW'(1);
            end else if (in_pulse && trail_edge) begin
                in_pulse <= 1'b0;
            end else if (in_pulse) begin
                cnt <= sat_inc(cnt);
            end
        end
    end

    assign meas_done = in_pulse & trail_edge;
    assign is_short  = (cnt < limit);
endmodule

// File: rtl/capture_trigger.sv
module capture_trigger
    import captrig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic [ADC_W-1:0]   adc_sample,
    input  logic [LOGIC_W-1:0] logic_in,
    input  logic [REG_W-1:0]   cfg_reg,
    input  logic [REG_W-1:0]   thr_lo_reg,
    input  logic [LOGIC_W-1:0] pat_value,
    input  logic [LOGIC_W-1:0] pat_mask,
    input  logic [REG_W-1:0]   holdoff_lo,
    input  logic [REG_W-1:0]   holdoff_hi,
    input  logic [REG_W-1:0]   width_limit,
    input  logic               ctl_fsm_reset,
    input  logic               ctl_arm,
    input  logic               ctl_force,
    output logic               trig_pulse,
    output logic [REG_W-1:0]   status
);
    trig_cfg_t        cfg;
    logic [ADC_W-1:0] thresh;
    logic             rise, fall, lead, trail;
    logic             pat_match;
    logic             meas_done, is_short;
    logic             cond, fire;
    seq_state_e       state;
    logic [HOLD_W-1:0] hold_cnt;

    assign cfg    = decode_cfg(cfg_reg);
    assign thresh = make_threshold(cfg, thr_lo_reg);
    assign lead   = cfg.falling ? fall : rise;
    assign trail  = cfg.falling ? rise : fall;

    captrig_level #(.W(ADC_W)) u_level (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .sample    (adc_sample),
        .thresh    (thresh),
        .rise      (rise),
        .fall      (fall)
    );

    captrig_pattern #(.W(LOGIC_W)) u_pattern (
        .data  (logic_in),
        .value (pat_value),
        .mask  (pat_mask),
        .match (pat_match)
    );

    captrig_width #(.CW(REG_W)) u_width (
        .clk        (clk),
        .rst        (rst),
        .track_en   (state == ST_HUNT),
        .smp_valid  (smp_valid),
        .lead_edge  (lead),
        .trail_edge (trail),
        .limit      (width_limit),
        .meas_done  (meas_done),
        .is_short   (is_short)
    );

    always_comb begin
        unique case (cfg.mode)
            MODE_LEVEL:   cond = lead;
            MODE_NARROW:  cond = meas_done & is_short;
            MODE_WIDE:    cond = meas_done & ~is_short;
            MODE_PATTERN: cond = smp_valid & pat_match;
            default:      cond = 1'b0;
        endcase
    end

    assign fire = ((state == ST_HUNT) & cfg.enable & cond) |
                  (((state == ST_HOLDOFF) | (state == ST_HUNT)) & ctl_force);

    always_ff @(posedge clk) begin
        if (rst || ctl_fsm_reset) begin
            state      <= ST_IDLE;
            hold_cnt   <= '0;
            trig_pulse <= 1'b0;
        end else begin
            trig_pulse <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ctl_arm) begin
                        state    <= ST_HOLDOFF;
                        hold_cnt <= {holdoff_hi, holdoff_lo};
                    end
                end
                ST_HOLDOFF: begin
                    if (fire) begin
                        state      <= ST_DONE;
                        trig_pulse <= 1'b1;
                    end else if (hold_cnt == '0) begin
                        state <= ST_HUNT;
                    end else if (smp_valid) begin
                        hold_cnt <= hold_cnt - 1'b1;
                    end
                end
                ST_HUNT: begin
                    if (fire) begin
                        state      <= ST_DONE;
                        trig_pulse <= 1'b1;
                    end
                end
                ST_DONE: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign status = (state == ST_DONE) ? STAT_READY : STAT_WAIT;
endmodule

// File: rtl/captrig_checker.sv
module captrig_checker
    import captrig_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             fsm_reset,
    input logic             force_in,
    input logic             cfg_en,
    input logic             trig,
    input logic [REG_W-1:0] status,
    input seq_state_e       st
);
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    assert_ready_with_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        trig |-> status == STAT_READY);

    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (status == STAT_READY && !fsm_reset) |=> status == STAT_READY);

    assert_seq_reset_R11: assert property (@(posedge clk) disable iff (rst)
        fsm_reset |=> (status == STAT_WAIT && !trig));

    assert_enable_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !force_in) |=> !trig);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |=> !trig);
endmodule

bind capture_trigger captrig_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .fsm_reset (ctl_fsm_reset),
    .force_in  (ctl_force),
    .cfg_en    (cfg_reg[7]),
    .trig      (trig_pulse),
    .status    (status),
    .st        (state)
);

// File: tb/capture_trigger_test.sv
module capture_trigger_test;
    import captrig_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic [9:0] adc_sample = '0;
    logic [7:0] logic_in = '0, cfg_reg = '0, thr_lo_reg = '0;
    logic [7:0] pat_value = '0, pat_mask = '0;
    logic [7:0] holdoff_lo = '0, holdoff_hi = '0, width_limit = '0;
    logic ctl_fsm_reset = 1'b0, ctl_arm = 1'b0, ctl_force = 1'b0;
    logic trig_pulse;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    capture_trigger uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .adc_sample(adc_sample),
        .logic_in(logic_in), .cfg_reg(cfg_reg), .thr_lo_reg(thr_lo_reg),
        .pat_value(pat_value), .pat_mask(pat_mask), .holdoff_lo(holdoff_lo),
        .holdoff_hi(holdoff_hi), .width_limit(width_limit),
        .ctl_fsm_reset(ctl_fsm_reset), .ctl_arm(ctl_arm), .ctl_force(ctl_force),
        .trig_pulse(trig_pulse), .status(status)
    );

    typedef struct packed {
        logic [7:0] cfg;
        logic [7:0] thr;
        logic [7:0] pv;
        logic [7:0] pm;
        logic [9:0] adc_a;
        logic [7:0] lg_a;
        logic [9:0] adc_b;
        logic [7:0] lg_b;
        logic       exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'h81, 8'h00, 8'h00, 8'hFF, 10'h0FF, 8'h00, 10'h100, 8'h00, 1'b1}, // R3 rising at threshold
        '{8'h81, 8'h00, 8'h00, 8'hFF, 10'h0FE, 8'h00, 10'h0FF, 8'h00, 1'b0}, // R3 just below
        '{8'h85, 8'h00, 8'h00, 8'hFF, 10'h200, 8'h00, 10'h0FF, 8'h00, 1'b1}, // R3 falling
        '{8'h85, 8'h00, 8'h00, 8'hFF, 10'h200, 8'h00, 10'h100, 8'h00, 1'b0}, // R3 stays high
        '{8'h01, 8'h00, 8'h00, 8'hFF, 10'h0FF, 8'h00, 10'h100, 8'h00, 1'b0}, // R2 disabled
        '{8'h83, 8'h00, 8'h00, 8'hFF, 10'h2FF, 8'h00, 10'h300, 8'h00, 1'b1}, // R3 high bits
        '{8'hE0, 8'h00, 8'hA5, 8'h0F, 10'h000, 8'h00, 10'h000, 8'hA3, 1'b1}, // R4 masked match
        '{8'hE0, 8'h00, 8'hA5, 8'h0F, 10'h000, 8'h00, 10'h000, 8'hB5, 1'b0}, // R4 mismatch
        '{8'h60, 8'h00, 8'h3C, 8'h00, 10'h000, 8'h3D, 10'h000, 8'h3C, 1'b0}  // R2 pattern disabled
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [9:0] a, input logic [7:0] l);
        adc_sample = a;
        logic_in   = l;
        smp_valid  = 1'b1;
        tick();
        smp_valid  = 1'b0;
    endtask

    task automatic arm_seq(input logic [15:0] hold);
        holdoff_hi    = hold[15:8];
        holdoff_lo    = hold[7:0];
        ctl_fsm_reset = 1'b1;
        tick();
        ctl_fsm_reset = 1'b0;
        ctl_arm       = 1'b1;
        tick();
        ctl_arm       = 1'b0;
        tick();
    endtask

    task automatic run_pulse(input logic [7:0] cfg, input int n, input logic exp, input string req);
        logic [9:0] base, other;
        int early;
        early = 0;
        cfg_reg = cfg;
        thr_lo_reg = 8'h00;
        width_limit = 8'd4;
        base  = cfg[2] ? 10'h180 : 10'h000;
        other = cfg[2] ? 10'h000 : 10'h180;
        arm_seq(16'd0);
        push(base, 8'h00);
        early += trig_pulse;
        for (int i = 0; i < n; i++) begin
            push(other, 8'h00);
            early += trig_pulse;
        end
        chk({req, " no early trigger"}, early, 0);
        push(base, 8'h00);
        chk({req, " trigger at closing edge"}, trig_pulse, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired (R10 flow)");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int early;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 status", status, 8'h01);
        chk("R1 trig", trig_pulse, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            cfg_reg    = VEC[v].cfg;
            thr_lo_reg = VEC[v].thr;
            pat_value  = VEC[v].pv;
            pat_mask   = VEC[v].pm;
            arm_seq(16'd0);
            push(VEC[v].adc_a, VEC[v].lg_a);
            chk($sformatf("R3/R4 vec%0d first sample quiet", v), trig_pulse, 0);
            push(VEC[v].adc_b, VEC[v].lg_b);
            chk($sformatf("R2/R3/R4 vec%0d trigger", v), trig_pulse, VEC[v].exp);
            chk($sformatf("R10 vec%0d status", v), status, VEC[v].exp ? 8'h02 : 8'h01);
        end

        // R9 force during holdoff with trigger disabled
        cfg_reg = 8'h01;
        arm_seq(16'd5);
        ctl_force = 1'b1;
        tick();
        ctl_force = 1'b0;
        chk("R9 force fires", trig_pulse, 1);
        chk("R10 status ready", status, 8'h02);
        tick();
        chk("R10 single pulse", trig_pulse, 0);
        // R8 arm after completion ignored
        ctl_arm = 1'b1;
        tick();
        ctl_arm = 1'b0;
        tick();
        chk("R8 arm ignored when done", status, 8'h02);
        push(10'h000, 8'h00);
        push(10'h3FF, 8'h00);
        chk("R10 ready holds, no retrigger", {trig_pulse, status}, {1'b0, 8'h02});
        // R11 sequencer reset
        ctl_fsm_reset = 1'b1;
        tick();
        ctl_fsm_reset = 1'b0;
        chk("R11 back to waiting", status, 8'h01);
        // R9 force in idle
        ctl_force = 1'b1;
        tick();
        ctl_force = 1'b0;
        chk("R9 force in idle ignored", {trig_pulse, status}, {1'b0, 8'h01});
        // R11 reset wins over arm
        ctl_fsm_reset = 1'b1;
        ctl_arm = 1'b1;
        tick();
        ctl_fsm_reset = 1'b0;
        ctl_arm = 1'b0;
        ctl_force = 1'b1;
        tick();
        ctl_force = 1'b0;
        chk("R11 reset priority over arm", {trig_pulse, status}, {1'b0, 8'h01});

        // R5 / R6 width qualification, limit 4
        run_pulse(8'hA1, 3, 1'b1, "R5 width3<4");
        run_pulse(8'hA1, 4, 1'b0, "R5 width4 not short");
        run_pulse(8'hC1, 4, 1'b1, "R6 width4>=4");
        run_pulse(8'hC1, 3, 1'b0, "R6 width3 too short");
        run_pulse(8'hC5, 5, 1'b1, "R6 falling width5");

        // R7 holdoff of 3 samples
        cfg_reg = 8'h81;
        thr_lo_reg = 8'h00;
        arm_seq(16'd3);
        early = 0;
        push(10'h000, 8'h00); early += trig_pulse;
        push(10'h180, 8'h00); early += trig_pulse;
        push(10'h000, 8'h00); early += trig_pulse;
        chk("R7 crossings in holdoff ignored", early, 0);
        tick();
        push(10'h180, 8'h00);
        chk("R7 fires after holdoff", trig_pulse, 1);

        // R7 holdoff using the high byte (256 samples)
        arm_seq(16'h0100);
        early = 0;
        for (int i = 0; i < 256; i++) begin
            push((i % 2) ? 10'h180 : 10'h000, 8'h00);
            early += trig_pulse;
        end
        chk("R7 high-byte holdoff quiet", early, 0);
        chk("R7 still waiting", status, 8'h01);
        tick();
        push(10'h000, 8'h00);
        push(10'h180, 8'h00);
        chk("R7 fires after long holdoff", trig_pulse, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule